// File: doc/BRIEF.md
# Scan Test Mode Control Wrapper

This block sits between a chip core and its pads and hands the chip over to full-scan manufacturing test. A three-bit mode pin bus is decoded into one test-mode qualifier. While that qualifier is high, the wrapper makes the following substitutions:

- Every internally generated or PLL-derived clock is replaced by the system clock pin.
- Every internally generated reset is replaced by one externally driven reset pin.
- Bidirectional pads are made to act as scan-chain inputs.
- Functional output pads carry the scan-chain outputs.
- Memory read data is replaced by the write data, so the memory macros drop out of the scan logic.

Pad ownership follows the decoded test mode and not scan enable. Scan enable passes straight to the core.

The wrapper is combinational. The only exception is an optional register stage on the decoded mode, chosen by a parameter. The register is clocked by the system clock and reset asynchronously by an active-low reset. The number of scan chains, bypassed clocks, overridden resets and memory ports are all parameters. Each chain has its own shared input pad and its own shared output pad.

Top module: `scan_test_wrap`

## Requirements
- R1: With REG_MODE = 0, `test_mode` is 1 exactly when `mode_pins` equals 3'b010 (bit 2 low, bit 1 high, bit 0 low). Every other code gives 0, and the change is visible in the same cycle.
- R2: With REG_MODE = 1, `test_mode` is 0 while `rst_n` is low. After reset it shows the decode of `mode_pins` that was sampled at the previous rising edge of `clk_sys`.
- R3: `scan_en_core` always equals `scan_en_pin`, in every mode (1 = shift, 0 = capture).
- R4: While `test_mode` is 1, every bit of `core_clks` equals `clk_sys`. Otherwise `core_clks` equals `int_clks`.
- R5: While `test_mode` is 1, `pad_oe` is all zero, whatever `pad_func_oe` is. `core_si` then equals `pad_di`.
- R6: While `test_mode` is 1, `opad_out` equals `core_so`.
- R7: While `test_mode` is 1, every bit of `core_rsts_n` equals `rst_pin_n`.
- R8: While `test_mode` is 1, `core_rdata` equals `mem_wdata`.
- R9: While `test_mode` is 0, all functional paths stay as they are:
  - `pad_oe` = `pad_func_oe`
  - `core_si` = 0
  - `opad_out` = `core_func_out`
  - `core_rsts_n` = `int_rsts_n`
  - `core_rdata` = `mem_rdata`
- R10: In every mode, `pad_do` equals `pad_func_out` and `core_pad_in` equals `pad_di`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock pin; also the scan clock |
| rst_n | input | 1 | Asynchronous active-low reset for the optional mode register |
| mode_pins | input | 3 | Mode pin bus |
| scan_en_pin | input | 1 | Scan enable pin (1 shift, 0 capture) |
| scan_en_core | output | 1 | Scan enable toward the core |
| test_mode | output | 1 | Decoded scan test qualifier |
| int_clks | input | NUM_CLKS | Internal and PLL-derived clocks |
| core_clks | output | NUM_CLKS | Clocks delivered to the core |
| int_rsts_n | input | NUM_RSTS | Internally generated resets, active low |
| rst_pin_n | input | 1 | External reset pin used during scan |
| core_rsts_n | output | NUM_RSTS | Resets delivered to the core |
| pad_func_oe | input | NUM_CHAINS | Core output enables for the shared bidirectional pads |
| pad_func_out | input | NUM_CHAINS | Core output data for the shared bidirectional pads |
| pad_di | input | NUM_CHAINS | Data received from the bidirectional pads |
| pad_oe | output | NUM_CHAINS | Output enables driven to the bidirectional pads |
| pad_do | output | NUM_CHAINS | Output data driven to the bidirectional pads |
| core_pad_in | output | NUM_CHAINS | Pad input data to the core's functional logic |
| core_si | output | NUM_CHAINS | Scan-chain inputs toward the core |
| core_func_out | input | NUM_CHAINS | Functional data for the shared output pads |
| core_so | input | NUM_CHAINS | Scan-chain outputs from the core |
| opad_out | output | NUM_CHAINS | Data driven to the shared output pads |
| mem_wdata | input | NUM_MEMS*MEM_DW | Write data from the core to the memories |
| mem_rdata | input | NUM_MEMS*MEM_DW | Read data from the memory macros |
| core_rdata | output | NUM_MEMS*MEM_DW | Read data delivered to the core |

## Verification
The bench builds two copies of the block, both with the defaults NUM_CHAINS = 64, NUM_CLKS = 4, NUM_RSTS = 3, NUM_MEMS = 2 and MEM_DW = 32. The first copy uses REG_MODE = 0 and the second uses REG_MODE = 1.

The full 64-chain width lets alternating and inverted bit patterns expose any per-chain mix-up between pads, scan paths and output muxes. The 64-bit memory bus does the same for the read-data bypass.

The combinational copy is walked through all eight mode codes, which covers the single-code decode and the keeping of functional behaviour. The registered copy brings the reset value and the one-edge mode latency within reach.

// File: rtl/scan_wrap_pkg.sv
package scan_wrap_pkg;
  localparam logic [2:0] SCAN_MODE_CODE = 3'b010;

  function automatic logic is_scan_code(input logic [2:0] code);
    return code == SCAN_MODE_CODE;
  endfunction
endpackage

// File: rtl/scan_mode_decode.sv
module scan_mode_decode
  import scan_wrap_pkg::*;
#(
  parameter bit REG_MODE = 1'b0
) (
  input  logic       clk_sys,
  input  logic       rst_n,
  input  logic [2:0] mode_pins,
  output logic       test_mode
);
  logic decoded;
  assign decoded = is_scan_code(mode_pins);

  generate
    if (REG_MODE) begin : g_reg
      logic tm_q, tm_d;
      always_comb tm_d = decoded;
      always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) tm_q <= 1'b0;
        else        tm_q <= tm_d;
      end
      assign test_mode = tm_q;
    end else begin : g_comb
      logic unused_inputs;
      assign unused_inputs = &{1'b0, clk_sys, rst_n};
      assign test_mode = decoded;
    end
  endgenerate
endmodule

// File: rtl/scan_bypass_mux.sv
module scan_bypass_mux #(
  parameter int W = 1
) (
  input  logic         sel_test,
  input  logic [W-1:0] func_in,
  input  logic [W-1:0] test_in,
  output logic [W-1:0] mux_out
);
  always_comb mux_out = sel_test ? test_in : func_in;
endmodule

// File: rtl/scan_pad_steer.sv
module scan_pad_steer #(
  parameter int NUM_CHAINS = 64
) (
  input  logic                  test_mode,
  input  logic [NUM_CHAINS-1:0] pad_func_oe,
  input  logic [NUM_CHAINS-1:0] pad_func_out,
  input  logic [NUM_CHAINS-1:0] pad_di,
  output logic [NUM_CHAINS-1:0] pad_oe,
  output logic [NUM_CHAINS-1:0] pad_do,
  output logic [NUM_CHAINS-1:0] core_pad_in,
  output logic [NUM_CHAINS-1:0] core_si,
  input  logic [NUM_CHAINS-1:0] core_func_out,
  input  logic [NUM_CHAINS-1:0] core_so,
  output logic [NUM_CHAINS-1:0] opad_out
);
  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    // bidirectional pad: forced to receive while in test mode
    always_comb begin
      pad_oe[c]      = pad_func_oe[c] & ~test_mode;
      pad_do[c]      = pad_func_out[c];
      core_pad_in[c] = pad_di[c];
      core_si[c]     = pad_di[c] & test_mode;
    end
    // shared output pad: scan-out replaces functional data
    always_comb opad_out[c] = test_mode ? core_so[c] : core_func_out[c];
  end
endmodule

// File: rtl/scan_test_wrap.sv
module scan_test_wrap #(
  parameter int NUM_CHAINS = 64,
  parameter int NUM_CLKS   = 4,
  parameter int NUM_RSTS   = 3,
  parameter int NUM_MEMS   = 2,
  parameter int MEM_DW     = 32,
  parameter bit REG_MODE   = 1'b0
) (
  input  logic                       clk_sys,
  input  logic                       rst_n,
  input  logic [2:0]                 mode_pins,
  input  logic                       scan_en_pin,
  output logic                       scan_en_core,
  output logic                       test_mode,
  input  logic [NUM_CLKS-1:0]        int_clks,
  output logic [NUM_CLKS-1:0]        core_clks,
  input  logic [NUM_RSTS-1:0]        int_rsts_n,
  input  logic                       rst_pin_n,
  output logic [NUM_RSTS-1:0]        core_rsts_n,
  input  logic [NUM_CHAINS-1:0]      pad_func_oe,
  input  logic [NUM_CHAINS-1:0]      pad_func_out,
  input  logic [NUM_CHAINS-1:0]      pad_di,
  output logic [NUM_CHAINS-1:0]      pad_oe,
  output logic [NUM_CHAINS-1:0]      pad_do,
  output logic [NUM_CHAINS-1:0]      core_pad_in,
  output logic [NUM_CHAINS-1:0]      core_si,
  input  logic [NUM_CHAINS-1:0]      core_func_out,
  input  logic [NUM_CHAINS-1:0]      core_so,
  output logic [NUM_CHAINS-1:0]      opad_out,
  input  logic [NUM_MEMS*MEM_DW-1:0] mem_wdata,
  input  logic [NUM_MEMS*MEM_DW-1:0] mem_rdata,
  output logic [NUM_MEMS*MEM_DW-1:0] core_rdata
);
  localparam int MEM_BUS_W = NUM_MEMS * MEM_DW;

  logic tm;

  scan_mode_decode #(.REG_MODE(REG_MODE)) u_decode (
    .clk_sys   (clk_sys),
    .rst_n     (rst_n),
    .mode_pins (mode_pins),
    .test_mode (tm)
  );

  assign test_mode    = tm;
  assign scan_en_core = scan_en_pin;

  scan_bypass_mux #(.W(NUM_CLKS)) u_clk_byp (
    .sel_test (tm),
    .func_in  (int_clks),
    .test_in  ({NUM_CLKS{clk_sys}}),
    .mux_out  (core_clks)
  );

  scan_bypass_mux #(.W(NUM_RSTS)) u_rst_byp (
    .sel_test (tm),
    .func_in  (int_rsts_n),
    .test_in  ({NUM_RSTS{rst_pin_n}}),
    .mux_out  (core_rsts_n)
  );

  scan_bypass_mux #(.W(MEM_BUS_W)) u_mem_byp (
    .sel_test (tm),
    .func_in  (mem_rdata),
    .test_in  (mem_wdata),
    .mux_out  (core_rdata)
  );

  scan_pad_steer #(.NUM_CHAINS(NUM_CHAINS)) u_pads (
    .test_mode     (tm),
    .pad_func_oe   (pad_func_oe),
    .pad_func_out  (pad_func_out),
    .pad_di        (pad_di),
    .pad_oe        (pad_oe),
    .pad_do        (pad_do),
    .core_pad_in   (core_pad_in),
    .core_si       (core_si),
    .core_func_out (core_func_out),
    .core_so       (core_so),
    .opad_out      (opad_out)
  );
endmodule

// File: rtl/scan_test_wrap_chk.sv
module scan_test_wrap_chk #(
  parameter int NUM_CHAINS = 64,
  parameter int NUM_CLKS   = 4,
  parameter int NUM_RSTS   = 3,
  parameter int NUM_MEMS   = 2,
  parameter int MEM_DW     = 32,
  parameter bit REG_MODE   = 1'b0
) (
  input logic                       clk_sys,
  input logic                       rst_n,
  input logic [2:0]                 mode_pins,
  input logic                       scan_en_pin,
  input logic                       scan_en_core,
  input logic                       test_mode,
  input logic [NUM_RSTS-1:0]        int_rsts_n,
  input logic                       rst_pin_n,
  input logic [NUM_RSTS-1:0]        core_rsts_n,
  input logic [NUM_CHAINS-1:0]      pad_func_oe,
  input logic [NUM_CHAINS-1:0]      pad_oe,
  input logic [NUM_CHAINS-1:0]      pad_di,
  input logic [NUM_CHAINS-1:0]      core_si,
  input logic [NUM_CHAINS-1:0]      core_func_out,
  input logic [NUM_CHAINS-1:0]      core_so,
  input logic [NUM_CHAINS-1:0]      opad_out,
  input logic [NUM_MEMS*MEM_DW-1:0] mem_wdata,
  input logic [NUM_MEMS*MEM_DW-1:0] mem_rdata,
  input logic [NUM_MEMS*MEM_DW-1:0] core_rdata
);
  logic past_ok;
  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  generate
    if (REG_MODE) begin : g_r2
      a_r2_mode_latency: assert property (@(posedge clk_sys) disable iff (!rst_n)
        past_ok |-> (test_mode == $past(mode_pins == 3'b010)));
    end else begin : g_r1
      a_r1_mode_decode: assert property (@(posedge clk_sys) disable iff (!rst_n)
        test_mode == (mode_pins == 3'b010));
    end
  endgenerate

  a_r3_se_pass: assert property (@(posedge clk_sys) disable iff (!rst_n)
    scan_en_core == scan_en_pin);
  a_r5_pads_input: assert property (@(posedge clk_sys) disable iff (!rst_n)
    test_mode |-> (pad_oe == '0 && core_si == pad_di));
  a_r6_scan_out: assert property (@(posedge clk_sys) disable iff (!rst_n)
    test_mode |-> opad_out == core_so);
  a_r7_reset_pin: assert property (@(posedge clk_sys) disable iff (!rst_n)
    test_mode |-> core_rsts_n == {NUM_RSTS{rst_pin_n}});
  a_r8_mem_bypass: assert property (@(posedge clk_sys) disable iff (!rst_n)
    test_mode |-> core_rdata == mem_wdata);
  a_r9_functional: assert property (@(posedge clk_sys) disable iff (!rst_n)
    !test_mode |-> (pad_oe == pad_func_oe && core_si == '0 &&
                    opad_out == core_func_out && core_rsts_n == int_rsts_n &&
                    core_rdata == mem_rdata));
endmodule

bind scan_test_wrap scan_test_wrap_chk #(
  .NUM_CHAINS(NUM_CHAINS), .NUM_CLKS(NUM_CLKS), .NUM_RSTS(NUM_RSTS),
  .NUM_MEMS(NUM_MEMS), .MEM_DW(MEM_DW), .REG_MODE(REG_MODE)
) u_chk (.*);

// File: tb/scan_test_wrap_bench.sv
module scan_test_wrap_bench;
  localparam int PER = 10;
  localparam int NC = 64, NK = 4, NR = 3, MW = 64;

  // entry: {mode[2:0], scan_en, expected test_mode}
  localparam logic [4:0] VEC [8] = '{
    {3'b000, 1'b0, 1'b0}, {3'b001, 1'b1, 1'b0},
    {3'b010, 1'b1, 1'b1}, {3'b011, 1'b0, 1'b0},
    {3'b100, 1'b1, 1'b0}, {3'b101, 1'b0, 1'b0},
    {3'b110, 1'b1, 1'b0}, {3'b111, 1'b0, 1'b0}
  };

  logic clk_sys = 1'b0;
  logic rst_n, scan_en_pin, rst_pin_n;
  logic [2:0] mode_pins;
  logic [NK-1:0] int_clks;
  logic [NR-1:0] int_rsts_n;
  logic [NC-1:0] pad_func_oe, pad_func_out, pad_di, core_func_out, core_so;
  logic [MW-1:0] mem_wdata, mem_rdata;

  logic se_c, tm_c;
  logic [NK-1:0] clks_c;
  logic [NR-1:0] rsts_c;
  logic [NC-1:0] oe_c, do_c, pin_c, si_c, op_c;
  logic [MW-1:0] rd_c;

  logic se_r, tm_r;
  logic [NK-1:0] clks_r;
  logic [NR-1:0] rsts_r;
  logic [NC-1:0] oe_r, do_r, pin_r, si_r, op_r;
  logic [MW-1:0] rd_r;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(PER/2) clk_sys = ~clk_sys;

  scan_test_wrap u_scan_test_wrap (
    .clk_sys, .rst_n, .mode_pins, .scan_en_pin, .scan_en_core(se_c),
    .test_mode(tm_c), .int_clks, .core_clks(clks_c), .int_rsts_n, .rst_pin_n,
    .core_rsts_n(rsts_c), .pad_func_oe, .pad_func_out, .pad_di, .pad_oe(oe_c),
    .pad_do(do_c), .core_pad_in(pin_c), .core_si(si_c), .core_func_out,
    .core_so, .opad_out(op_c), .mem_wdata, .mem_rdata, .core_rdata(rd_c));

  scan_test_wrap #(.REG_MODE(1'b1)) u_scan_test_wrap_reg (
    .clk_sys, .rst_n, .mode_pins, .scan_en_pin, .scan_en_core(se_r),
    .test_mode(tm_r), .int_clks, .core_clks(clks_r), .int_rsts_n, .rst_pin_n,
    .core_rsts_n(rsts_r), .pad_func_oe, .pad_func_out, .pad_di, .pad_oe(oe_r),
    .pad_do(do_r), .core_pad_in(pin_r), .core_si(si_r), .core_func_out,
    .core_so, .opad_out(op_r), .mem_wdata, .mem_rdata, .core_rdata(rd_r));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(PER * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; mode_pins = 3'b010; scan_en_pin = 1'b0; rst_pin_n = 1'b1;
    int_clks = 4'b1010; int_rsts_n = 3'b101;
    pad_func_oe = '1; pad_func_out = '0; pad_di = '0;
    core_func_out = '0; core_so = '0; mem_wdata = '0; mem_rdata = '0;

    // R2: reset holds registered qualifier low
    repeat (3) @(negedge clk_sys);
    chk("R2 reset value", 64'(tm_r), 64'd0);
    rst_n = 1'b1;
    #1 chk("R2 before first edge", 64'(tm_r), 64'd0);
    @(posedge clk_sys); #2;
    chk("R2 one edge later", 64'(tm_r), 64'd1);
    @(negedge clk_sys); mode_pins = 3'b000; #1;
    chk("R2 holds until edge", 64'(tm_r), 64'd1);
    chk("R1 same cycle", 64'(tm_c), 64'd0);
    @(posedge clk_sys); #2;
    chk("R2 drops after edge", 64'(tm_r), 64'd0);

    // table walk over all mode codes
    for (int i = 0; i < 8; i++) begin
      logic [2:0] m; logic se, tm;
      logic [63:0] pat;
      {m, se, tm} = VEC[i];
      pat = (i % 2 == 0) ? 64'hA5C3_0F96_3C5A_F069 : 64'h0123_4567_89AB_CDEF;
      @(negedge clk_sys);
      mode_pins = m; scan_en_pin = se; rst_pin_n = i[0];
      pad_func_oe = pat; pad_func_out = ~pat; pad_di = {pat[31:0], pat[63:32]};
      core_func_out = pat ^ 64'hFFFF_0000_FFFF_0000; core_so = ~{pat[31:0], pat[63:32]};
      mem_rdata = pat + 64'd7; mem_wdata = ~pat;
      int_rsts_n = pat[2:0];
      #1;
      chk("R1 decode", 64'(tm_c), 64'(tm));
      chk("R3 scan enable", 64'(se_c), 64'(se));
      chk(tm ? "R5 pad oe" : "R9 pad oe", oe_c, tm ? 64'd0 : pad_func_oe);
      chk(tm ? "R5 scan in" : "R9 scan in", si_c, tm ? pad_di : 64'd0);
      chk(tm ? "R6 scan out" : "R9 out pad", op_c, tm ? core_so : core_func_out);
      chk(tm ? "R7 resets" : "R9 resets", 64'(rsts_c),
          tm ? 64'({NR{rst_pin_n}}) : 64'(int_rsts_n));
      chk(tm ? "R8 mem" : "R9 mem", rd_c, tm ? mem_wdata : mem_rdata);
      chk("R10 pad data out", do_c, pad_func_out);
      chk("R10 pad data in", pin_c, pad_di);
    end

    // R4: clock bypass in both clock phases
    for (int m = 0; m < 2; m++) begin
      @(negedge clk_sys);
      mode_pins = (m == 1) ? 3'b010 : 3'b110;
      int_clks = 4'b0110;
      @(posedge clk_sys); #2;
      chk(m == 1 ? "R4 clocks high" : "R9 clocks high", 64'(clks_c),
          m == 1 ? 64'hF : 64'h6);
      @(negedge clk_sys); #2;
      chk(m == 1 ? "R4 clocks low" : "R9 clocks low", 64'(clks_c),
          m == 1 ? 64'h0 : 64'h6);
    end

    done = 1;
    finish_run();
  end
endmodule